// File: doc/BRIEF.md
# Half-Precision 3x3 Max Pooling Sorter

This block reduces a 3x3 pooling window of nine half-precision (FP16) operands to its largest value. All nine operands arrive in parallel with a single strobe. The result and its own strobe come out a fixed 35 cycles later. A new window may be presented on every clock, so a stream of windows gives a stream of maxima in the same order.

The nine operands are spread over sixteen network lanes. The seven unused lanes hold FP16 negative infinity, so they never affect the result. Each operand is first turned into an unsigned ordering key. Two eight-lane groups are sorted by a bitonic compare-exchange network, one group rising and the other falling. One final compare between the two group tops picks the winner. There are seven compare levels in all, and each level spends five register stages. A NaN anywhere in a window replaces that window's result with the canonical quiet NaN.

Top module: `pool_max3x3_fp16`

## Requirements
- R1: For a window with no NaN, out_max equals the largest of the nine operands under IEEE FP16 numeric ordering.
- R2: out_valid rises exactly 35 clock cycles after the cycle in which in_valid was sampled high, together with that window's result.
- R3: A window can be accepted on every cycle; results of consecutive windows come out on consecutive cycles in the order the windows went in.
- R4: +0 (0x0000) and -0 (0x8000) compare equal; when the winning value is zero, out_max is 0x0000, never 0x8000.
- R5: +infinity (0x7C00) beats every finite value; -infinity (0xFC00) loses to every other value; a window made only of -infinity yields 0xFC00.
- R6: If any operand is a NaN (exponent field bits 14..10 all ones, mantissa bits 9..0 nonzero), out_max is 0x7E00 for that window.
- R7: While rst_n is low, and for the windows in flight when it went low, out_valid stays low; no result from a window accepted before the reset ever appears.
- R8: out_valid is high only in cycles that correspond to a window accepted 35 cycles earlier; idle input cycles produce no output strobe.
- R9: Operand k (k = 0..8) sits in in_win bits [16k+15:16k]; the result does not depend on which position holds the maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A window is presented on in_win this cycle |
| in_win | input | 144 | Nine FP16 operands, operand k at bits [16k+15:16k] |
| out_valid | output | 1 | out_max holds a window result this cycle |
| out_max | output | 16 | Maximum of the window, or 0x7E00 if the window held a NaN |

## Verification
The hard cases are windows whose maximum sits in the ninth operand. That operand is the only one sorted inside the group that is otherwise all padding, so the deciding comparison is the final cross-group one. The stimulus places the largest value at each of the nine positions in turn, with the other operands close to it. Ties between +0 and -0 and all-negative windows are also hard, because a wrong sign or key mapping only shows there. Directed windows of mixed-sign zeros, negatives and infinities are mixed with random FP16 streams sent back to back and with random gaps. A reset arrives while windows are in flight, and the bench checks that none of them comes out.

// File: rtl/pool_fp16_pkg.sv
package pool_fp16_pkg;

  parameter int unsigned FP_W    = 16;
  parameter int unsigned WIN_N   = 9;
  parameter int unsigned LANES   = 16;
  parameter int unsigned GRP     = LANES / 2;

  typedef logic [FP_W-1:0]             fp16_t;
  typedef logic [LANES-1:0][FP_W-1:0]  lane_vec_t;

  localparam fp16_t FP16_NEG_INF = 16'hFC00;
  localparam fp16_t FP16_QNAN    = 16'h7E00;
  localparam fp16_t FP16_NEG_ZERO = 16'h8000;

  // Unsigned key whose order matches FP16 numeric order.
  function automatic logic [FP_W-1:0] order_key(input fp16_t v);
    return v[FP_W-1] ? ~v : {1'b1, v[FP_W-2:0]};
  endfunction

  function automatic logic is_nan(input fp16_t v);
    return (&v[14:10]) && (|v[9:0]);
  endfunction

  // Fold -0 onto +0 so both zeros carry one key.
  function automatic fp16_t canon_zero(input fp16_t v);
    return (v == FP16_NEG_ZERO) ? '0 : v;
  endfunction

  // Bitonic schedule for a group of g lanes: phase size of level l.
  function automatic int level_k(input int l, input int g);
    int n, r;
    n = 0;
    r = 0;
    for (int k = 2; k <= g; k = k * 2)
      for (int j = k / 2; j > 0; j = j / 2) begin
        if (n == l) r = k;
        n++;
      end
    return r;
  endfunction

  // Partner distance of level l.
  function automatic int level_j(input int l, input int g);
    int n, r;
    n = 0;
    r = 0;
    for (int k = 2; k <= g; k = k * 2)
      for (int j = k / 2; j > 0; j = j / 2) begin
        if (n == l) r = j;
        n++;
      end
    return r;
  endfunction

endpackage

// File: rtl/pool_rst_sync.sv
module pool_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/pool_cx_level.sv
module pool_cx_level
  import pool_fp16_pkg::*;
#(
  parameter int unsigned LAT   = 5,
  parameter int unsigned K     = 2,
  parameter int unsigned J     = 1,
  parameter bit          FINAL = 1'b0
) (
  input  logic      clk,
  input  logic      en,
  input  lane_vec_t d_in,
  output lane_vec_t d_out
);

  lane_vec_t            cx_nxt;
  lane_vec_t [LAT-1:0]  dly_q;

  // Next-state: one compare-exchange level over all lanes.
  always_comb begin
    cx_nxt = d_in;
    if (FINAL) begin
      if (order_key(d_in[GRP-1]) > order_key(d_in[GRP])) cx_nxt[0] = d_in[GRP-1];
      else                                               cx_nxt[0] = d_in[GRP];
    end else begin
      for (int i = 0; i < int'(LANES); i++) begin
        int  p;
        logic up, swap;
        p = i ^ int'(J);
        if (p > i) begin
          up   = ((i & int'(K)) == 0);
          swap = up ? (order_key(d_in[i]) > order_key(d_in[p]))
                    : (order_key(d_in[i]) < order_key(d_in[p]));
          if (swap) begin
            cx_nxt[i] = d_in[p];
            cx_nxt[p] = d_in[i];
          end
        end
      end
    end
  end

  // Register: the level's multi-cycle compare latency.
  always_ff @(posedge clk) begin
    if (en) begin
      dly_q[0] <= cx_nxt;
      for (int s = 1; s < int'(LAT); s++) dly_q[s] <= dly_q[s-1];
    end
  end

  assign d_out = dly_q[LAT-1];

endmodule

// File: rtl/pool_max3x3_fp16.sv
module pool_max3x3_fp16
  import pool_fp16_pkg::*;
#(
  parameter int unsigned LAT_CMP = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [WIN_N*FP_W-1:0]  in_win,
  output logic                   out_valid,
  output logic [FP_W-1:0]        out_max
);

  localparam int unsigned GRP_LOG     = $clog2(GRP);
  localparam int unsigned SORT_LEVELS = GRP_LOG * (GRP_LOG + 1) / 2;
  localparam int unsigned NUM_LEVELS  = SORT_LEVELS + 1;
  localparam int unsigned LATENCY     = NUM_LEVELS * LAT_CMP;
  localparam int unsigned SORT_LAT    = SORT_LEVELS * LAT_CMP;

  logic                 srst_n;
  logic                 pipe_en;
  logic                 win_nan;
  lane_vec_t            lane_in;
  lane_vec_t            lvl [NUM_LEVELS];
  logic [LATENCY-1:0]   vld_q, vld_nxt;
  logic [LATENCY-1:0]   nan_q, nan_nxt;

  pool_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Lane fill: nine operands, padding lanes hold -infinity.
  always_comb begin
    win_nan = 1'b0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (l < int'(WIN_N)) begin
        lane_in[l] = canon_zero(in_win[l*FP_W +: FP_W]);
        win_nan    = win_nan | is_nan(in_win[l*FP_W +: FP_W]);
      end else begin
        lane_in[l] = FP16_NEG_INF;
      end
    end
  end

  assign pipe_en = in_valid | (|vld_q);

  genvar g;
  generate
    for (g = 0; g < int'(NUM_LEVELS); g++) begin : g_level
      lane_vec_t lvl_in;
      if (g == 0) begin : g_first
        assign lvl_in = lane_in;
      end else begin : g_next
        assign lvl_in = lvl[g-1];
      end
      pool_cx_level #(
        .LAT   (LAT_CMP),
        .K     ((g < int'(SORT_LEVELS)) ? level_k(g, GRP) : 0),
        .J     ((g < int'(SORT_LEVELS)) ? level_j(g, GRP) : 0),
        .FINAL (g == int'(SORT_LEVELS))
      ) u_level (
        .clk   (clk),
        .en    (pipe_en),
        .d_in  (lvl_in),
        .d_out (lvl[g])
      );
    end
  endgenerate

  // Valid and NaN flags travel beside the data.
  always_comb begin
    vld_nxt = {vld_q[LATENCY-2:0], in_valid};
    nan_nxt = {nan_q[LATENCY-2:0], win_nan};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= '0;
    else         vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (pipe_en) nan_q <= nan_nxt;
  end

  assign out_valid = vld_q[LATENCY-1];
  assign out_max   = nan_q[LATENCY-1] ? FP16_QNAN : lvl[NUM_LEVELS-1][0];

  // Checks: after the sort levels each group must be monotone.
  logic groups_sorted;
  always_comb begin
    groups_sorted = 1'b1;
    for (int i = 0; i < int'(GRP) - 1; i++) begin
      if (order_key(lvl[SORT_LEVELS-1][i]) > order_key(lvl[SORT_LEVELS-1][i+1]))
        groups_sorted = 1'b0;
      if (order_key(lvl[SORT_LEVELS-1][GRP+i]) < order_key(lvl[SORT_LEVELS-1][GRP+i+1]))
        groups_sorted = 1'b0;
    end
  end

  assert_groups_sorted_R1: assert property (@(posedge clk) disable iff (!srst_n)
    vld_q[SORT_LAT-1] |-> groups_sorted);

  assert_result_not_nan_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !nan_q[LATENCY-1]) |-> !is_nan(out_max));

  assert_nan_quiet_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && nan_q[LATENCY-1]) |-> (out_max == FP16_QNAN));

  assert_no_neg_zero_R4: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (out_max != FP16_NEG_ZERO));

endmodule

// File: tb/pool_max3x3_fp16_tb.sv
module pool_max3x3_fp16_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 35;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [143:0] in_win;
  logic         out_valid;
  logic [15:0]  out_max;

  typedef struct {
    int          due;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    cyc;
  int    checks;
  int    errors;
  bit    rst_active;
  string idle_tag;

  pool_max3x3_fp16 u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_win    (in_win),
    .out_valid (out_valid),
    .out_max   (out_max)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic real fval(input logic [15:0] v);
    real mag;
    int  e, m;
    e = int'(v[14:10]);
    m = int'(v[9:0]);
    if (e == 31)     mag = 1.0e30;
    else if (e == 0) mag = real'(m) * (2.0 ** -24);
    else             mag = real'(1024 + m) * (2.0 ** (e - 25));
    return v[15] ? -mag : mag;
  endfunction

  function automatic logic [15:0] ref_max(input logic [143:0] w);
    logic [15:0] best, v;
    best = w[15:0];
    for (int k = 0; k < 9; k++) begin
      v = w[k*16 +: 16];
      if (v[14:10] == 5'h1F && v[9:0] != 0) return 16'h7E00;
      if (fval(v) > fval(best)) best = v;
    end
    if (best == 16'h8000) best = 16'h0000;
    return best;
  endfunction

  function automatic logic [15:0] rnd_fp();
    logic [15:0] v;
    int          sel;
    sel = int'($urandom_range(0, 9));
    v   = 16'($urandom);
    if (sel == 0)      v = {v[15], 15'h0};
    else if (sel == 1) v = {v[15], 15'h7C00};
    else if (v[14:10] == 5'h1F) v[14] = 1'b0;
    return v;
  endfunction

  function automatic logic [143:0] rnd_win();
    logic [143:0] w;
    for (int k = 0; k < 9; k++) w[k*16 +: 16] = rnd_fp();
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [16:0] act,
                       input logic [16:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual valid/value %h expected %h", tag, cyc, act, expv);
    end
  endtask

  task automatic compare();
    if (rst_active) begin
      check(!out_valid, "R7", {out_valid, out_max}, {1'b0, 16'h0});
    end else if (q.size() > 0 && q[0].due == cyc) begin
      check(out_valid && out_max == q[0].val, q[0].tag,
            {out_valid, out_max}, {1'b1, q[0].val});
      void'(q.pop_front());
    end else begin
      check(!out_valid, idle_tag, {out_valid, out_max}, {1'b0, 16'h0});
    end
  endtask

  task automatic tick(input bit v, input logic [143:0] w, input string tag);
    @(negedge clk);
    compare();
    in_valid = v;
    in_win   = w;
    if (v) q.push_back('{cyc + LAT, ref_max(w), tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, "");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    logic [143:0] w;
    checks     = 0;
    errors     = 0;
    idle_tag   = "R8";
    rst_active = 1'b1;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_win     = '0;

    // R7: reset state
    repeat (4) begin @(negedge clk); compare(); end
    @(negedge clk); compare(); rst_n = 1'b1;
    repeat (3) begin @(negedge clk); compare(); end
    rst_active = 1'b0;
    idle(3);

    // R2: single window, exact latency
    w = '0;
    for (int k = 0; k < 9; k++) w[k*16 +: 16] = 16'h3C00 + 16'(k);
    tick(1'b1, w, "R2");
    idle(40);

    // R3: back-to-back random windows
    for (int n = 0; n < 200; n++) tick(1'b1, rnd_win(), "R3");
    // R1: random windows with random gaps
    for (int n = 0; n < 300; n++) tick(($urandom_range(0, 2) != 0), rnd_win(), "R1");
    // R1: all-negative windows
    for (int n = 0; n < 50; n++) begin
      w = rnd_win();
      for (int k = 0; k < 9; k++) w[k*16+15] = 1'b1;
      tick(1'b1, w, "R1");
    end

    // R4: signed zeros
    w = '0;
    for (int k = 0; k < 9; k++) w[k*16 +: 16] = 16'h8000;
    tick(1'b1, w, "R4");
    w[3*16 +: 16] = 16'h0000;
    tick(1'b1, w, "R4");
    for (int k = 0; k < 9; k++) w[k*16 +: 16] = (k % 2 == 0) ? 16'hBC00 : 16'h8000;
    tick(1'b1, w, "R4");
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 9; k++)
        w[k*16 +: 16] = ($urandom_range(0, 1) != 0) ? {1'b1, 15'($urandom)} : {$urandom_range(0,1) != 0, 15'h0};
      for (int k = 0; k < 9; k++) if (w[k*16+14 -: 5] == 5'h1F) w[k*16+14] = 1'b0;
      tick(1'b1, w, "R4");
    end

    // R5: infinities
    for (int p = 0; p < 9; p++) begin
      w = rnd_win();
      for (int k = 0; k < 9; k++) if (w[k*16+14 -: 5] == 5'h1F) w[k*16 +: 16] = 16'h3800;
      w[p*16 +: 16] = 16'h7C00;
      tick(1'b1, w, "R5");
    end
    for (int k = 0; k < 9; k++) w[k*16 +: 16] = 16'hFC00;
    tick(1'b1, w, "R5");
    w[8*16 +: 16] = 16'hFBFF;
    tick(1'b1, w, "R5");

    // R6: NaN at each position
    for (int p = 0; p < 9; p++) begin
      w = rnd_win();
      w[p*16 +: 16] = {($urandom_range(0, 1) != 0), 5'h1F, 10'($urandom_range(1, 1023))};
      tick(1'b1, w, "R6");
    end

    // R9: maximum at each position among close neighbours
    for (int p = 0; p < 9; p++) begin
      for (int k = 0; k < 9; k++) w[k*16 +: 16] = 16'h4500 + 16'(k);
      w[p*16 +: 16] = 16'h4510;
      tick(1'b1, w, "R9");
      for (int k = 0; k < 9; k++) w[k*16 +: 16] = 16'hC510 - 16'(k);
      w[p*16 +: 16] = 16'hC4F0;
      tick(1'b1, w, "R9");
    end
    idle(40);

    // R7: reset with windows in flight
    for (int n = 0; n < 12; n++) tick(1'b1, rnd_win(), "R7");
    @(negedge clk); compare();
    rst_n = 1'b0; rst_active = 1'b1; in_valid = 1'b0; q.delete();
    repeat (3) begin @(negedge clk); compare(); end
    @(negedge clk); compare(); rst_n = 1'b1;
    repeat (3) begin @(negedge clk); compare(); end
    rst_active = 1'b0;
    idle_tag = "R7";
    idle(45);
    idle_tag = "R8";

    // traffic after reset still works
    for (int n = 0; n < 30; n++) tick(1'b1, rnd_win(), "R3");
    idle(45);

    finish_run();
  end

endmodule